// File: doc/BRIEF.md
# Two-Step Critical Command Sequencer

This block sits behind a command decoder and protects one critical action. Every command arrives as a decoded code with a one-cycle valid strobe. Ordinary codes are acknowledged at once and leave the block idle. The critical action is split into two commands: an arming code and a firing code. The firing code causes a one-clock action pulse only if it arrives while the block is armed and before the armed window expires.

Once armed, the block expects the firing code and nothing else. Any other code, or silence for the whole window, is a sequence fault. After a fault the block disarms and sets a sticky error flag. It also increments a saturating error tally. A firing code that arrives while idle is a fault as well. All outputs are registered, so each reacts on the clock edge that captures the command.

Top module: `arm_fire_seq`

## Requirements
- R1: A firing code (default 4'h5) captured while armed produces `ack` and a one-cycle `action` pulse in the next cycle, and `armed` drops. `action` is never high two cycles in a row.
- R2: An arming code (default 4'hA) captured while idle raises `ack` and `armed` in the next cycle, and restarts the window count.
- R3: While armed, any valid code other than the firing code, including a second arming code, is a fault. The block then disarms, and `ack` and `action` stay low.
- R4: The armed window is TIMEOUT cycles after the arming edge. A firing code in any of those cycles, including the last, is accepted. With no command in all of them, a fault is raised and `armed` drops after exactly TIMEOUT cycles.
- R5: A firing code captured while idle is a fault. It produces no `ack` and no `action`.
- R6: Any other code captured while idle is acknowledged, and the block stays disarmed.
- R7: `err_flag` stays set until `err_clr` is high. When a fault and `err_clr` occur in the same cycle, the flag ends up set.
- R8: `err_count` adds one per fault and saturates at 255. `err_clr` clears it to 0, or to 1 if a fault occurs in the same cycle.
- R9: After reset, `ack`, `action`, `armed`, `err_flag` and `err_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle strobe: `cmd_code` holds a command |
| cmd_code | input | CMD_W | Decoded command code |
| err_clr | input | 1 | Clears the error flag and the error count |
| ack | output | 1 | Command accepted (one cycle) |
| action | output | 1 | Critical action pulse (one cycle) |
| armed | output | 1 | Block is waiting for the firing code |
| err_flag | output | 1 | Sticky sequence-fault flag |
| err_count | output | CNT_W | Saturating fault tally |

## Verification
The assertions assume a command is a single-cycle event on `cmd_valid`, with `cmd_code` meaningful only while the strobe is high. They also assume `err_clr` may arrive at any time, including together with a fault. The stimulus drives every input at the falling edge and holds it for exactly one cycle. Idle gaps are shaped so that the firing code lands on the last cycle of the window and on the cycle after it. The bench also drives a clear together with a fault, and a long run of faults that drives the tally into saturation.

// File: rtl/arm_fire_seq.sv
module arm_fire_seq #(
  parameter int CMD_W   = 4,
  parameter int TIMEOUT = 16,
  parameter int CNT_W   = 8,
  parameter logic [CMD_W-1:0] CODE_ARM  = 4'hA,
  parameter logic [CMD_W-1:0] CODE_FIRE = 4'h5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic             err_clr,
  output logic             ack,
  output logic             action,
  output logic             armed,
  output logic             err_flag,
  output logic [CNT_W-1:0] err_count
);
  localparam int TW = (TIMEOUT < 2) ? 1 : $clog2(TIMEOUT);
  localparam logic [TW-1:0]    LAST = TW'(TIMEOUT - 1);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [TW-1:0] tmr_q;

  wire is_arm  = cmd_valid && (cmd_code == CODE_ARM);
  wire is_fire = cmd_valid && (cmd_code == CODE_FIRE);
  wire expire  = armed && !cmd_valid && (tmr_q == LAST);
  wire fault   = armed ? ((cmd_valid && !is_fire) || expire) : is_fire;
  wire accept  = cmd_valid && !fault;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      tmr_q     <= '0;
      ack       <= 1'b0;
      action    <= 1'b0;
      err_flag  <= 1'b0;
      err_count <= '0;
    end else begin
      ack    <= accept;
      action <= armed && is_fire;
      armed  <= armed ? !(cmd_valid || expire) : is_arm;
      tmr_q  <= (armed && !cmd_valid) ? tmr_q + 1'b1 : '0;
      err_flag <= fault || (err_flag && !err_clr);
      if (err_clr)
        err_count <= fault ? CNT_W'(1) : '0;
      else if (fault && err_count != CMAX)
        err_count <= err_count + 1'b1;
    end
  end

  a_r1_action_from_armed: assert property (@(posedge clk) disable iff (!rst_n)
    action |-> $past(armed) && !armed && ack);
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    action |=> !action);
  a_r4_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> tmr_q <= LAST);
  a_r5_idle_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && is_fire) |=> !ack && !action && err_flag);
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);
  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == CMAX && !err_clr) |=> err_count == CMAX);
endmodule

// File: tb/arm_fire_seq_tb.sv
module arm_fire_seq_tb_top;
  localparam int CLK_PER = 10;
  localparam int TO = 4;
  localparam logic [3:0] ARM = 4'hA, FIRE = 4'h5, NOP = 4'h3;

  logic clk = 0, rst_n = 0, cmd_valid = 0, err_clr = 0;
  logic [3:0] cmd_code = '0;
  logic ack, action, armed, err_flag;
  logic [7:0] err_count;

  typedef struct { logic a, x, m, f; int c; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  logic eflag = 0;
  int ecnt = 0;
  bit done = 0;

  arm_fire_seq #(.TIMEOUT(TO)) dut_i (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .err_clr(err_clr), .ack(ack), .action(action), .armed(armed),
    .err_flag(err_flag), .err_count(err_count));

  always #(CLK_PER/2) clk = ~clk;

  task automatic step(input logic v, input logic [3:0] code, input logic clr,
                      input logic ea, input logic ex, input logic em, input logic flt,
                      input string tag);
    exp_t e;
    @(negedge clk);
    cmd_valid = v; cmd_code = code; err_clr = clr;
    if (clr) begin eflag = flt; ecnt = flt ? 1 : 0; end
    else if (flt) begin eflag = 1; if (ecnt < 255) ecnt++; end
    e.a = ea; e.x = ex; e.m = em; e.f = eflag; e.c = ecnt; e.tag = tag;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #(CLK_PER/4);
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (ack !== e.a || action !== e.x || armed !== e.m || err_flag !== e.f || int'(err_count) != e.c) begin
        fails++;
        $display("FAIL %s: got ack=%b act=%b arm=%b flag=%b cnt=%0d exp ack=%b act=%b arm=%b flag=%b cnt=%0d",
          e.tag, ack, action, armed, err_flag, err_count, e.a, e.x, e.m, e.f, e.c);
      end
    end
  end

  initial begin
    #(CLK_PER * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got hang exp finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (ack || action || armed || err_flag || err_count != 0) begin
      fails++;
      $display("FAIL R9 reset: got %b%b%b%b cnt=%0d exp 0000 cnt=0", ack, action, armed, err_flag, err_count);
    end
    rst_n = 1;
    step(1, NOP, 0, 1, 0, 0, 0, "R6 idle plain code acked");
    step(0, NOP, 0, 0, 0, 0, 0, "R6 idle gap");
    step(1, ARM, 0, 1, 0, 1, 0, "R2 arm acked");
    step(0, NOP, 0, 0, 0, 1, 0, "R2 stays armed");
    step(1, FIRE, 0, 1, 1, 0, 0, "R1 fire action pulse");
    step(0, NOP, 0, 0, 0, 0, 0, "R1 pulse one cycle");
    step(1, FIRE, 0, 0, 0, 0, 1, "R5 fire while idle");
    step(0, NOP, 1, 0, 0, 0, 0, "R7 R8 clear");
    step(1, ARM, 0, 1, 0, 1, 0, "R2 arm again");
    step(1, NOP, 0, 0, 0, 0, 1, "R3 plain code while armed");
    step(1, ARM, 0, 1, 0, 1, 0, "R2 arm");
    step(1, ARM, 0, 0, 0, 0, 1, "R3 second arm while armed");
    step(0, NOP, 0, 0, 0, 0, 0, "R7 flag sticky");
    step(1, ARM, 0, 1, 0, 1, 0, "R4 arm for timeout");
    for (int i = 1; i < TO; i++) step(0, NOP, 0, 0, 0, 1, 0, "R4 inside window");
    step(0, NOP, 0, 0, 0, 0, 1, "R4 timeout disarms");
    step(1, ARM, 0, 1, 0, 1, 0, "R4 arm for late fire");
    for (int i = 1; i < TO; i++) step(0, NOP, 0, 0, 0, 1, 0, "R4 waiting");
    step(1, FIRE, 0, 1, 1, 0, 0, "R4 fire on last window cycle");
    step(1, ARM, 0, 1, 0, 1, 0, "R4 arm for expired fire");
    for (int i = 0; i < TO; i++) step(0, NOP, 0, 0, 0, (i < TO-1), (i == TO-1), "R4 window runs out");
    step(1, FIRE, 0, 0, 0, 0, 1, "R4 fire after expiry");
    step(1, FIRE, 1, 0, 0, 0, 1, "R7 R8 fault with clear");
    for (int i = 0; i < 260; i++) step(1, FIRE, 0, 0, 0, 0, 1, "R8 saturation");
    step(0, NOP, 0, 0, 0, 0, 0, "R8 held at max");
    step(0, NOP, 1, 0, 0, 0, 0, "R8 clear from max");
    step(0, NOP, 0, 0, 0, 0, 0, "R7 cleared flag stays low");
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule